// File: doc/BRIEF.md
# Seconds Real-Time Clock with Byte Access

This block keeps a 32-bit count of seconds measured from the start of 1904. A prescaled clock-enable input feeds a sub-second divider. When the divider has seen `TICKS_PER_SEC` enables, the count steps by one and a single-cycle event pulse goes to an interrupt unit. The count wraps modulo 2^32.

Software reaches the clock through a small command port. Each command is presented for one cycle with a code, an argument count and up to four argument bytes. A read command returns the count as four bytes, most significant first. A load command replaces the count with four argument bytes and restarts the sub-second phase. A load therefore adds a full second before the next step.

At reset the count starts at `INIT_UNIX` plus 2082844800. That constant moves a 1970-based seconds value onto the 1904 origin.

Top module: `rtc_secs_top`

## Requirements
- R1: After reset, a read returns `INIT_UNIX + 2082844800` (mod 2^32). Before any command, `rsp_valid` and `sec_pulse` are 0.
- R2: A read command (code `CODE_READ`, `arg_cnt` = 0) makes `rsp_valid` = 1 and `rsp_len` = 4 in the next cycle. `rsp_data` then holds the count as it stood before that edge: byte 0, the most significant, is in `rsp_data[31:24]` and byte 3 is in `rsp_data[7:0]`.
- R3: A load command (code `CODE_LOAD`, `arg_cnt` = 4) sets the count to `arg_data`, with byte 0 in `[31:24]` taken as most significant. The sub-second phase restarts, so the next step comes exactly `TICKS_PER_SEC` enables later.
- R4: A well-formed load answers with `rsp_valid` = 1, `rsp_len` = 0 and `rsp_data` = 0.
- R5: A read whose `arg_cnt` is not 0, or a load whose `arg_cnt` is not 4, leaves the count and the phase unchanged. It answers with `rsp_valid` = 1 and `rsp_len` = 0.
- R6: The count advances by one for every `TICKS_PER_SEC` cycles that have `tick_en` = 1. Cycles without `tick_en` do not advance it.
- R7: `sec_pulse` is high for exactly one cycle: the first cycle in which the stepped count is visible. Successive pulses are exactly `TICKS_PER_SEC` enables apart, whatever reads happen in between.
- R8: The count wraps from 0xFFFFFFFF to 0.
- R9: A read in the cycle of a step returns the value before the step. A load in the cycle of a step takes priority: the loaded value is kept and no pulse is raised.
- R10: A command with any other code gives no response and leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Prescaled clock enable for the sub-second divider |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_code | input | 8 | Command code |
| arg_cnt | input | 3 | Number of argument bytes supplied |
| arg_data | input | 32 | Argument bytes, byte 0 in [31:24] |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_len | output | 3 | Response length in bytes |
| rsp_data | output | 32 | Response bytes, byte 0 (MSB) in [31:24] |
| sec_pulse | output | 1 | One-second event pulse |

## Verification
The step from the divider can fall in the same cycle as a command, and the two cases resolve differently.

- **Read during a step.** After a load, the bench waits exactly `TICKS_PER_SEC - 1` enables and then issues a read. The read must return the pre-step value while `sec_pulse` rises in that same cycle. A following read must show the stepped value.
- **Load during a step.** The bench lines up a load on a step edge in the same way. The loaded value must survive, `sec_pulse` must stay low, and the next pulse must come a full second of enables later.

// File: rtl/rtc_secs_pkg.sv
package rtc_secs_pkg;
  // Seconds between 1904-01-01 and 1970-01-01
  localparam logic [31:0] EPOCH_SHIFT_1904 = 32'd2082844800;
  localparam int unsigned NUM_BYTES = 4;
  localparam int unsigned CNT_W     = 8 * NUM_BYTES;
  localparam int unsigned LEN_W     = 3;

  typedef enum logic [1:0] {
    REQ_NONE = 2'd0,
    REQ_READ = 2'd1,
    REQ_LOAD = 2'd2,
    REQ_BAD  = 2'd3
  } req_e;
endpackage

// File: rtl/rtc_rst_sync.sv
module rtc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rtc_phase_div.sv
module rtc_phase_div #(
  parameter int unsigned TICKS_PER_SEC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic restart,
  output logic step
);
  localparam int unsigned PW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICKS_PER_SEC - 1);

  logic [PW-1:0] phase_q;
  logic [PW-1:0] phase_d;
  logic          at_last;

  assign at_last = (phase_q == LAST);
  assign step    = tick_en && at_last && !restart;

  always_comb begin
    phase_d = phase_q;
    if (restart)      phase_d = '0;
    else if (tick_en) phase_d = at_last ? '0 : phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end
endmodule

// File: rtl/rtc_secs_reg.sv
module rtc_secs_reg
  import rtc_secs_pkg::*;
#(
  parameter logic [CNT_W-1:0] INIT_UNIX = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] secs,
  output logic             sec_pulse
);
  localparam logic [CNT_W-1:0] RESET_SECS = INIT_UNIX + EPOCH_SHIFT_1904;

  logic [CNT_W-1:0] secs_q, secs_d;
  logic             pulse_q, pulse_d;

  always_comb begin
    secs_d  = secs_q;
    pulse_d = 1'b0;
    if (load) begin
      secs_d = load_val;
    end else if (step) begin
      secs_d  = secs_q + 1'b1;
      pulse_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      secs_q  <= RESET_SECS;
      pulse_q <= 1'b0;
    end else begin
      secs_q  <= secs_d;
      pulse_q <= pulse_d;
    end
  end

  assign secs      = secs_q;
  assign sec_pulse = pulse_q;
endmodule

// File: rtl/rtc_cmd_unit.sv
module rtc_cmd_unit
  import rtc_secs_pkg::*;
#(
  parameter logic [7:0] CODE_READ = 8'h21,
  parameter logic [7:0] CODE_LOAD = 8'h22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_code,
  input  logic [2:0]       arg_cnt,
  input  logic [CNT_W-1:0] arg_data,
  input  logic [CNT_W-1:0] secs,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             rsp_valid,
  output logic [LEN_W-1:0] rsp_len,
  output logic [CNT_W-1:0] rsp_data
);
  req_e             req;
  logic             vld_q, vld_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [CNT_W-1:0] dat_q, dat_d;
  logic [CNT_W-1:0] lane_bytes;

  always_comb begin
    req = REQ_NONE;
    if (cmd_valid) begin
      if (cmd_code == CODE_READ)
        req = (arg_cnt == 3'd0) ? REQ_READ : REQ_BAD;
      else if (cmd_code == CODE_LOAD)
        req = (arg_cnt == 3'(NUM_BYTES)) ? REQ_LOAD : REQ_BAD;
    end
  end

  // byte lanes: lane 0 is the most significant byte of the count
  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_lane
    localparam int unsigned HI = CNT_W - 1 - 8 * b;
    assign lane_bytes[HI -: 8] = secs[HI -: 8];
    assign load_val[HI -: 8]   = arg_data[HI -: 8];
  end

  assign load = (req == REQ_LOAD);

  always_comb begin
    vld_d = (req != REQ_NONE);
    len_d = '0;
    dat_d = '0;
    if (req == REQ_READ) begin
      len_d = LEN_W'(NUM_BYTES);
      dat_d = lane_bytes;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      len_q <= '0;
      dat_q <= '0;
    end else begin
      vld_q <= vld_d;
      len_q <= len_d;
      dat_q <= dat_d;
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_len   = len_q;
  assign rsp_data  = dat_q;
endmodule

// File: rtl/rtc_secs_top.sv
module rtc_secs_top
  import rtc_secs_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 1000,
  parameter logic [31:0] INIT_UNIX     = 32'd0,
  parameter logic [7:0]  CODE_READ     = 8'h21,
  parameter logic [7:0]  CODE_LOAD     = 8'h22
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        cmd_valid,
  input  logic [7:0]  cmd_code,
  input  logic [2:0]  arg_cnt,
  input  logic [31:0] arg_data,
  output logic        rsp_valid,
  output logic [2:0]  rsp_len,
  output logic [31:0] rsp_data,
  output logic        sec_pulse
);
  logic             rst_sync_n;
  logic             step;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] secs;

  rtc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rtc_phase_div #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_div (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick_en (tick_en),
    .restart (load),
    .step    (step)
  );

  rtc_secs_reg #(.INIT_UNIX(INIT_UNIX)) u_secs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .step      (step),
    .load      (load),
    .load_val  (load_val),
    .secs      (secs),
    .sec_pulse (sec_pulse)
  );

  rtc_cmd_unit #(.CODE_READ(CODE_READ), .CODE_LOAD(CODE_LOAD)) u_cmd (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .arg_cnt   (arg_cnt),
    .arg_data  (arg_data),
    .secs      (secs),
    .load      (load),
    .load_val  (load_val),
    .rsp_valid (rsp_valid),
    .rsp_len   (rsp_len),
    .rsp_data  (rsp_data)
  );
endmodule

// File: rtl/rtc_secs_chk.sv
module rtc_secs_chk #(
  parameter logic [7:0] CODE_READ = 8'h21,
  parameter logic [7:0] CODE_LOAD = 8'h22
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic [7:0]  cmd_code,
  input logic [2:0]  arg_cnt,
  input logic [31:0] arg_data,
  input logic        rsp_valid,
  input logic [2:0]  rsp_len,
  input logic [31:0] rsp_data,
  input logic        sec_pulse,
  input logic [31:0] secs,
  input logic        step
);
  logic is_rd, is_ld;
  assign is_rd = cmd_valid && (cmd_code == CODE_READ);
  assign is_ld = cmd_valid && (cmd_code == CODE_LOAD);

  AST_READ_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    is_rd && arg_cnt == 3'd0 |=> rsp_valid && rsp_len == 3'd4 && rsp_data == $past(secs)); // R2
  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    is_ld && arg_cnt == 3'd4 |=> secs == $past(arg_data) && !sec_pulse); // R3
  AST_LOAD_NO_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
    is_ld |=> rsp_valid && rsp_len == 3'd0 && rsp_data == 32'd0); // R4
  AST_BAD_LOAD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    is_ld && arg_cnt != 3'd4 && !step |=> $stable(secs)); // R5
  AST_STEP_ADDS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> secs == $past(secs) + 32'd1 && sec_pulse); // R6
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |=> !sec_pulse); // R7
  AST_UNKNOWN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !is_rd && !is_ld |=> !rsp_valid); // R10
endmodule

bind rtc_secs_top rtc_secs_chk #(.CODE_READ(CODE_READ), .CODE_LOAD(CODE_LOAD)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cmd_valid (cmd_valid),
  .cmd_code  (cmd_code),
  .arg_cnt   (arg_cnt),
  .arg_data  (arg_data),
  .rsp_valid (rsp_valid),
  .rsp_len   (rsp_len),
  .rsp_data  (rsp_data),
  .sec_pulse (sec_pulse),
  .secs      (secs),
  .step      (step)
);

// File: tb/rtc_secs_top_tb_top.sv
`timescale 1ns/1ps
module rtc_secs_top_tb_top;
  localparam int          N     = 10;
  localparam logic [31:0] INIT  = 32'd100;
  localparam logic [31:0] SHIFT = 32'd2082844800;
  localparam logic [7:0]  RD    = 8'h21;
  localparam logic [7:0]  LD    = 8'h22;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_code = '0;
  logic [2:0] arg_cnt = '0;
  logic [31:0] arg_data = '0;
  logic rsp_valid;
  logic [2:0] rsp_len;
  logic [31:0] rsp_data;
  logic sec_pulse;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rtc_secs_top #(.TICKS_PER_SEC(N), .INIT_UNIX(INIT), .CODE_READ(RD), .CODE_LOAD(LD)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .arg_cnt(arg_cnt), .arg_data(arg_data),
    .rsp_valid(rsp_valid), .rsp_len(rsp_len), .rsp_data(rsp_data),
    .sec_pulse(sec_pulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the command edge
  task automatic do_cmd(input logic [7:0] c, input logic [2:0] n, input logic [31:0] d);
    cmd_valid = 1'b1; cmd_code = c; arg_cnt = n; arg_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; arg_cnt = '0; arg_data = '0;
  endtask

  task automatic edges_to_pulse(output int n);
    n = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      n++;
      if (sec_pulse) break;
    end
  endtask

  task automatic t_reset;
    chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R1 sec_pulse", {31'd0, sec_pulse}, 32'd0);
    do_cmd(RD, 3'd0, 32'd0);
    chk("R1 reset count", rsp_data, INIT + SHIFT);
    chk("R2 rsp_valid", {31'd0, rsp_valid}, 32'd1);
    chk("R2 rsp_len", {29'd0, rsp_len}, 32'd4);
  endtask

  task automatic t_load_count;
    int n;
    tick_en = 1'b1;
    do_cmd(LD, 3'd4, 32'h12345678);
    chk("R4 load rsp_valid", {31'd0, rsp_valid}, 32'd1);
    chk("R4 load rsp_len", {29'd0, rsp_len}, 32'd0);
    chk("R4 load rsp_data", rsp_data, 32'd0);
    edges_to_pulse(n);
    chk("R3 phase restart", n, N);
    do_cmd(RD, 3'd0, 32'd0);
    chk("R2 R3 byte order after step", rsp_data, 32'h12345679);
    chk("R7 pulse width", {31'd0, sec_pulse}, 32'd0);
    edges_to_pulse(n);
    chk("R7 pulse spacing with read between", n + 1, N);
  endtask

  task automatic t_gating;
    int n;
    logic [31:0] v;
    tick_en = 1'b0;
    do_cmd(RD, 3'd0, 32'd0);
    v = rsp_data;
    repeat (50) @(negedge clk);
    do_cmd(RD, 3'd0, 32'd0);
    chk("R6 no enable no advance", rsp_data, v);
    fork
      begin
        for (int i = 0; i < 400; i++) begin
          tick_en = ~tick_en;
          @(negedge clk);
          if (sec_pulse) break;
        end
      end
    join
    do_cmd(RD, 3'd0, 32'd0);
    chk("R6 half-rate enable advances one", rsp_data, v + 32'd1);
    tick_en = 1'b0;
    n = 0;
  endtask

  task automatic t_malformed;
    logic [31:0] v;
    tick_en = 1'b0;
    do_cmd(LD, 3'd4, 32'hA0B0C0D0);
    v = 32'hA0B0C0D0;
    do_cmd(LD, 3'd3, 32'h11111111);
    chk("R5 short load rsp_valid", {31'd0, rsp_valid}, 32'd1);
    chk("R5 short load rsp_len", {29'd0, rsp_len}, 32'd0);
    do_cmd(RD, 3'd1, 32'd0);
    chk("R5 read with args len", {29'd0, rsp_len}, 32'd0);
    chk("R5 read with args data", rsp_data, 32'd0);
    do_cmd(RD, 3'd0, 32'd0);
    chk("R5 count unchanged", rsp_data, v);
    do_cmd(8'h55, 3'd4, 32'h22222222);
    chk("R10 unknown no response", {31'd0, rsp_valid}, 32'd0);
    do_cmd(RD, 3'd0, 32'd0);
    chk("R10 count unchanged", rsp_data, v);
  endtask

  task automatic t_wrap;
    int n;
    tick_en = 1'b1;
    do_cmd(LD, 3'd4, 32'hFFFFFFFF);
    edges_to_pulse(n);
    do_cmd(RD, 3'd0, 32'd0);
    chk("R8 wrap to zero", rsp_data, 32'd0);
  endtask

  task automatic t_collide;
    int n;
    tick_en = 1'b1;
    do_cmd(LD, 3'd4, 32'h00000500);
    repeat (N - 1) @(negedge clk);
    do_cmd(RD, 3'd0, 32'd0);
    chk("R9 read at step sees old", rsp_data, 32'h00000500);
    chk("R9 pulse in step cycle", {31'd0, sec_pulse}, 32'd1);
    do_cmd(RD, 3'd0, 32'd0);
    chk("R9 next read sees new", rsp_data, 32'h00000501);
    do_cmd(LD, 3'd4, 32'h00000600);
    repeat (N - 1) @(negedge clk);
    do_cmd(LD, 3'd4, 32'h00000700);
    chk("R9 load at step no pulse", {31'd0, sec_pulse}, 32'd0);
    edges_to_pulse(n);
    chk("R9 full second after colliding load", n, N);
    do_cmd(RD, 3'd0, 32'd0);
    chk("R9 load wins", rsp_data, 32'h00000701);
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_load_count();
    t_gating();
    t_malformed();
    t_wrap();
    t_collide();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule